// File: doc/BRIEF.md
# Run-Time Sized Base Address Register Bank

This block holds a bank of base address registers, each paired with a mask register that software programs first. The mask decides two things: how large the window of the base register is, and whether that window sits in I/O space or in memory space. Both kinds of register are 32-bit dwords. They are written and read through a plain configuration port that carries an index, a write strobe, four byte enables and write data, and returns read data combinationally.

A base register keeps only the address bits that its mask allows. The low attribute bits it reports (the space indicator, and for memory windows the prefetch flag and the two-bit type) are copied from the mask. Masking and attributes are captured when the base register is written, so a new mask has no effect until the base register is written again. The second half of the block is an address decoder. A lookup request enters on a valid/ready stream, is compared against every enabled window, and one cycle later leaves as a registered hit vector on a second valid/ready stream. A request is taken whenever the output slot is empty or is being drained in that same cycle. While the output is valid and not taken, it holds its value.

Top module: `bar_mask_cfg`

## Requirements
- R1: After reset every configuration index reads 0, the output stream is idle, the input stream is ready, and no lookup hits any window.
- R2: Index layout: bit 3 of `cfg_idx` set selects a mask register, and clear selects a base register. Bits 2:0 give the slot number. A mask reads back exactly as written.
- R3: A base register bit whose committed mask bit is 0 reads as 0. A bit whose mask bit is 1 keeps the written value.
- R4: A mask with bit 0 = 1 makes an I/O window. The base reads bit 0 as 1 and bit 1 as 0, and its address field spans bits 31:2.
- R5: A mask with bit 0 = 0 makes a memory window. The base reads mask bits 3:1 in its bits 3:1 and reads bit 0 as 0. Its address field spans bits 31:4, and bits 31:24 are always writable whatever the mask holds there.
- R6: Writing a mask changes neither the readback nor the decoding of its base register until that base register is written again. Rewriting the base with the same value then applies the new mask.
- R7: Byte enables on any configuration write update only the enabled bytes. The disabled bytes keep their prior readback value.
- R8: A lookup hits a window when its space type matches and all address bits under the committed mask equal the stored base. Bits outside the mask are ignored.
- R9: A lookup whose space type differs from a window's type never hits that window.
- R10: A window whose committed address field is all zero, or that has never been written, never hits.
- R11: Lookups follow valid/ready on both sides. `dec_ready` equals not `out_valid` or `out_ready`, an accepted request appears on `out_valid` in the next cycle, and a stalled output holds `out_hit`. Results leave in request order.
- R12: Indices naming a slot at or beyond `NUM_BARS` read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx | input | 4 | Register index: bit 3 selects mask, bits 2:0 select slot |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_idx` (combinational) |
| dec_valid | input | 1 | Lookup request valid |
| dec_ready | output | 1 | Lookup request accepted when high with `dec_valid` |
| dec_addr | input | 32 | Address to decode |
| dec_is_io | input | 1 | 1 = I/O space lookup, 0 = memory space lookup |
| out_valid | output | 1 | Hit vector valid |
| out_ready | input | 1 | Consumer takes the hit vector |
| out_hit | output | 6 | One hit flag per slot |

## Verification
The hardest state to reach is a window whose mask has been rewritten while its base register has not. In that state the mask readback and the base readback disagree, and decoding must still follow the old window. The stimulus programs slot 0 with a narrow I/O window and confirms a hit. It then widens the mask and looks up an address that only the new window would cover, expecting a miss. Finally it rewrites the base with its old value and expects that same address to hit. All lookups run while the consumer stalls every third cycle, so results queue up behind back-pressure and are compared in order against a queue of expected hit vectors.

// File: rtl/bar_mask_pkg.sv
package bar_mask_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned BW = DW / 8;

  // Address bits a committed mask makes live in its base register.
  function automatic logic [DW-1:0] live_addr_bits(input logic [DW-1:0] m);
    if (m[0]) return {m[DW-1:2], 2'b00};
    else      return {8'hFF, m[DW-9:4], 4'h0};
  endfunction

  // Low attribute bits a committed mask reports through its base register.
  function automatic logic [DW-1:0] attr_bits(input logic [DW-1:0] m);
    if (m[0]) return {{(DW-1){1'b0}}, 1'b1};
    else      return {{(DW-4){1'b0}}, m[3:1], 1'b0};
  endfunction

  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_v,
                                                input logic [DW-1:0] new_v,
                                                input logic [BW-1:0] be);
    logic [DW-1:0] r;
    r = old_v;
    for (int i = 0; i < int'(BW); i++)
      if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/bar_slot.sv
module bar_slot
  import bar_mask_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic          base_we,
  input  logic [BW-1:0] be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] base_rd,
  input  logic [DW-1:0] look_addr,
  input  logic          look_io,
  output logic          hit
);
  logic [DW-1:0] mask_r, commit_r, base_r;
  logic          seen_r;
  logic [DW-1:0] live_c, merged_c;

  assign live_c  = seen_r ? live_addr_bits(commit_r) : '0;
  assign base_rd = seen_r ? ((base_r & live_c) | attr_bits(commit_r)) : '0;
  assign mask_q  = mask_r;
  assign merged_c = merge_bytes(base_rd, wdata, be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r   <= '0;
      commit_r <= '0;
      base_r   <= '0;
      seen_r   <= 1'b0;
    end else begin
      if (mask_we) mask_r <= merge_bytes(mask_r, wdata, be);
      if (base_we) begin
        commit_r <= mask_r;
        seen_r   <= 1'b1;
        base_r   <= merged_c & live_addr_bits(mask_r);
      end
    end
  end

  assign hit = (live_c != '0) && (look_io == commit_r[0]) &&
               (((look_addr ^ base_r) & live_c) == '0);

  // R6: committed window moves only on a base write
  p_window_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !base_we |=> ($stable(commit_r) && $stable(base_r)));
  // R4: an I/O base never reports bit 1
  p_io_bit1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    base_rd[0] |-> !base_rd[1]);
  // R5: memory base written with all-ones top byte keeps it
  p_mem_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && !mask_r[0] && be[3] && wdata[31:24] == 8'hFF) |=> base_rd[31:24] == 8'hFF);
endmodule

// File: rtl/bar_hit_stage.sv
module bar_hit_stage #(
  parameter int unsigned NUM_BARS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NUM_BARS-1:0] in_hit,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NUM_BARS-1:0] out_hit
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_hit <= in_hit;
    end
  end

  // R11: stalled result holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit)));
  // R11: accepted request shows up next cycle
  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/bar_mask_cfg.sv
module bar_mask_cfg
  import bar_mask_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6,
  parameter int unsigned SEL_W    = 3,
  localparam int unsigned IDX_W   = SEL_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_we,
  input  logic [BW-1:0]       cfg_be,
  input  logic [DW-1:0]       cfg_wdata,
  output logic [DW-1:0]       cfg_rdata,
  input  logic                dec_valid,
  output logic                dec_ready,
  input  logic [DW-1:0]       dec_addr,
  input  logic                dec_is_io,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NUM_BARS-1:0] out_hit
);
  logic                pick_mask;
  logic [SEL_W-1:0]    pick_slot;
  logic [DW-1:0]       mask_v [NUM_BARS];
  logic [DW-1:0]       base_v [NUM_BARS];
  logic [NUM_BARS-1:0] hit_v;

  assign pick_mask = cfg_idx[IDX_W-1];
  assign pick_slot = cfg_idx[SEL_W-1:0];

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
    logic sel;
    assign sel = cfg_we && (pick_slot == SEL_W'(g));
    bar_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_we  (sel && pick_mask),
      .base_we  (sel && !pick_mask),
      .be       (cfg_be),
      .wdata    (cfg_wdata),
      .mask_q   (mask_v[g]),
      .base_rd  (base_v[g]),
      .look_addr(dec_addr),
      .look_io  (dec_is_io),
      .hit      (hit_v[g])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < int'(NUM_BARS); i++)
      if (pick_slot == SEL_W'(i))
        cfg_rdata = pick_mask ? mask_v[i] : base_v[i];
  end

  bar_hit_stage #(.NUM_BARS(NUM_BARS)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (dec_valid),
    .in_ready (dec_ready),
    .in_hit   (hit_v),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_hit  (out_hit)
  );

  // R1: first cycle after reset the output is idle
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/bar_mask_cfg_bench.sv
`timescale 1ns/1ps
module bar_mask_cfg_bench;
  localparam int NB = 6;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dec_valid = 1'b0, dec_ready, dec_is_io = 1'b0;
  logic [31:0] dec_addr = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [NB-1:0] out_hit;

  bar_mask_cfg u_bar_mask_cfg (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [NB-1:0] exp_q[$];
  string         tag_q[$];

  logic [31:0] m_mask[NB], m_com[NB], m_base[NB];
  logic        m_seen[NB];

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] d, logic [3:0] be);
    for (int i = 0; i < 4; i++) if (be[i]) o[8*i +: 8] = d[8*i +: 8];
    return o;
  endfunction
  function automatic logic [31:0] live_of(logic [31:0] m);
    return m[0] ? {m[31:2], 2'b00} : {8'hFF, m[23:4], 4'h0};
  endfunction
  function automatic logic [31:0] attr_of(logic [31:0] m);
    return m[0] ? 32'h1 : {28'h0, m[3:1], 1'b0};
  endfunction
  function automatic logic [NB-1:0] exp_hit(logic [31:0] a, logic io);
    logic [NB-1:0] h = '0;
    for (int b = 0; b < NB; b++) begin
      logic [31:0] lv;
      lv = m_seen[b] ? live_of(m_com[b]) : 32'h0;
      h[b] = (lv != 0) && (io == m_com[b][0]) && (((a ^ m_base[b]) & lv) == 0);
    end
    return h;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [3:0] idx, logic [3:0] be, logic [31:0] d);
    int s;
    s = int'(idx[2:0]);
    @(negedge clk);
    cfg_idx = idx; cfg_be = be; cfg_wdata = d; cfg_we = 1'b1;
    if (s < NB) begin
      if (idx[3]) m_mask[s] = mrg(m_mask[s], d, be);
      else begin
        logic [31:0] old;
        old = m_seen[s] ? (m_base[s] | attr_of(m_com[s])) : 32'h0;
        m_com[s]  = m_mask[s];
        m_seen[s] = 1'b1;
        m_base[s] = mrg(old, d, be) & live_of(m_mask[s]);
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_read(logic [3:0] idx, logic [31:0] exp, string req);
    cfg_we = 1'b0; cfg_idx = idx;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic lookup(logic [31:0] a, logic io, string req);
    @(negedge clk);
    exp_q.push_back(exp_hit(a, io));
    tag_q.push_back(req);
    dec_addr = a; dec_is_io = io; dec_valid = 1'b1;
    while (!dec_ready) @(negedge clk);
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 100) begin @(negedge clk); n++; end
    check("R11 drain", exp_q.size(), 0);
  endtask

  // back-pressure: consumer stalls every third cycle
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready <= (cyc % 3) != 0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected result actual=%h expected=none", out_hit);
      end else begin
        logic [NB-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(out_hit), 32'(e));
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_mask[b] = 0; m_com[b] = 0; m_base[b] = 0; m_seen[b] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 16; i++) check_read(4'(i), 32'h0, "R1 reset read");
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 dec_ready", 32'(dec_ready), 1);
    lookup(32'h0000_0000, 1'b1, "R1 io lookup after reset");
    lookup(32'hFF00_0000, 1'b0, "R10 mem lookup unwritten");

    // R4/R3: I/O window on slot 0
    cfg_write(4'h8, 4'hF, 32'hFFFF_FF01);
    check_read(4'h8, 32'hFFFF_FF01, "R2 mask readback");
    cfg_write(4'h0, 4'hF, 32'h0000_1234);
    check_read(4'h0, 32'h0000_1201, "R3 R4 io base masked");

    // R5: memory window on slot 1, top byte forced writable
    cfg_write(4'h9, 4'hF, 32'h00F0_000C);
    cfg_write(4'h1, 4'hF, 32'hFEDC_BA98);
    check_read(4'h1, 32'hFED0_000C, "R5 mem base attr");

    // R7: byte enables
    cfg_write(4'hA, 4'hF, 32'hFFFF_FFFF);
    cfg_write(4'hA, 4'h1, 32'h0000_0000);
    check_read(4'hA, 32'hFFFF_FF00, "R7 mask byte enable");
    cfg_write(4'h2, 4'h8, 32'hAB00_0000);
    cfg_write(4'h2, 4'h2, 32'h1234_5566);
    check_read(4'h2, 32'hAB00_5500, "R7 base byte enable");

    // R8 hits under back-pressure
    lookup(32'h0000_12FF, 1'b1, "R8 io hit slot0");
    lookup(32'hFED1_2345, 1'b0, "R8 mem hit slot1");
    lookup(32'hAB00_55FF, 1'b0, "R8 mem hit slot2");
    lookup(32'hFED1_2345, 1'b1, "R9 space mismatch");
    lookup(32'hAB00_56FF, 1'b0, "R8 mem miss slot2");

    // R6: mask change deferred until base rewrite
    cfg_write(4'h8, 4'hF, 32'hFFFF_0001);
    check_read(4'h8, 32'hFFFF_0001, "R6 new mask visible");
    check_read(4'h0, 32'h0000_1201, "R6 base unchanged");
    lookup(32'h0000_13FF, 1'b1, "R6 old window still used");
    cfg_write(4'h0, 4'hF, 32'h0000_1201);
    check_read(4'h0, 32'h0000_0001, "R6 rewrite applies mask");
    lookup(32'h0000_13FF, 1'b1, "R6 new window hits");

    // R10: empty address field never hits
    cfg_write(4'hB, 4'hF, 32'h0000_0001);
    cfg_write(4'h3, 4'hF, 32'hFFFF_FFFF);
    check_read(4'h3, 32'h0000_0001, "R10 empty window readback");
    lookup(32'h0000_0000, 1'b1, "R10 empty window no hit");

    // R12: out-of-range slots
    cfg_write(4'h7, 4'hF, 32'hFFFF_FFFF);
    cfg_write(4'hE, 4'hF, 32'hFFFF_FFFF);
    check_read(4'h7, 32'h0, "R12 base slot7");
    check_read(4'hE, 32'h0, "R12 mask slot6");
    check_read(4'h6, 32'h0, "R12 base slot6");
    check_read(4'h0, 32'h0000_0001, "R12 slot0 untouched");

    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule